// File: doc/BRIEF.md
# Masked Control Register File

This block holds the sixteen 32-bit control registers of a small processor core, together with its program counter. Software reaches the registers through one write port and one combinational read port, each addressed by a 4-bit index. Every register carries two build-time masks. The writable mask lists the bits that software may change. The read-only mask lists the bits that keep their value across a software write. A bit that appears in neither mask is reserved: it is never set, so it always reads as zero. A register whose two masks are both empty is therefore reserved as a whole.

Two parameters choose the masks. `EXT_IRQ_CTRL` says whether interrupts come from an external vectoring controller or from the core's own pending and enable pair. `HAS_MMU` says whether the translation registers and the privilege fields of the status word exist. Two hardware inputs update read-only content directly and bypass the masks: a pending-interrupt vector and an exception-cause load. The program counter has its own load port and takes a parameterised address at reset.

Top module: `cregs_file`

Register indices (software decodes these): 0 status, 1 saved status on exception, 2 saved status on break, 3 interrupt enable, 4 interrupt pending, 5 core id, 7 exception cause, 8 page-table address, 9 TLB access, 10 TLB miscellany, 12 faulting address. Indices 6, 11, 13, 14 and 15 are reserved.

Status fields: bit 0 PIE (interrupts on), bit 1 U (user mode), bit 2 EH (exception handler active), bit 3 IH, bits 9:4 IL (interrupt level), bits 15:10 CRS (current register set), bits 21:16 PRS (previous register set), bit 22 NMI, bit 23 RSIE.

## Requirements
- R1: A write to index i stores (wr_data AND writable(i)) OR (current value AND read-only(i)). The new value is visible on rd_data from the clock edge that takes the write.
- R2: Reserved registers (indices 6, 11, 13, 14, 15) and all bits outside both masks read as zero, whatever is written.
- R3: Status bit 0 (PIE) is writable in every configuration.
- R4: Indices 1, 2 and 12 are fully writable. Index 5 (core id) and index 7 (exception cause) are fully read-only, so software writes leave them unchanged.
- R5: With EXT_IRQ_CTRL=1, status RSIE (23), PRS (21:16), IL (9:4) and IH (3) are writable, and NMI (22) and CRS (15:10) are read-only. With EXT_IRQ_CTRL=0, RSIE is read-only, and PRS, IL, IH, NMI and CRS are reserved.
- R6: With EXT_IRQ_CTRL=0, index 3 is fully writable, and index 4 takes hw_pend at every clock edge while ignoring software writes. With EXT_IRQ_CTRL=1, indices 3 and 4 are reserved.
- R7: With HAS_MMU=1, status U (1) and EH (2) are writable. Index 8 bits 31:2 are writable. Index 9 is fully writable. Index 10 has bits 23:18 and 13:6 writable and bits 5:0 read-only. With HAS_MMU=0, all of these are reserved.
- R8: During and after reset, every register reads zero except status, which reads 0x0080_0000 (RSIE only), and core id, which reads CORE_ID. pc_q reads RESET_PC.
- R9: hw_exc_we loads hw_exc_cause into index 7 at the clock edge. The new value is visible from that edge.
- R10: pc_we loads pc_wdata into pc_q at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software write strobe |
| wr_idx | input | 4 | Software write index |
| wr_data | input | 32 | Software write data |
| rd_idx | input | 4 | Read index |
| rd_data | output | 32 | Read data (combinational) |
| hw_pend | input | 32 | Pending interrupt lines (internal controller mode) |
| hw_exc_we | input | 1 | Exception cause load strobe |
| hw_exc_cause | input | 32 | Exception cause value |
| pc_we | input | 1 | Program counter load strobe |
| pc_wdata | input | 32 | Program counter load value |
| pc_q | output | 32 | Program counter |

## Verification
The bench drives two instances side by side with the same stimulus. The first uses EXT_IRQ_CTRL=0 and HAS_MMU=1. This reaches the pending and enable pair, the read-only RSIE bit and every translation field. The second uses EXT_IRQ_CTRL=1 and HAS_MMU=0. This reaches the writable register-set and level fields, the read-only NMI and CRS fields, and the reserved translation and interrupt registers. Directed all-ones and all-zeros writes to every index expose each mask. Random writes with changing pending vectors then exercise the merge rule.

// File: rtl/cregs_pkg.sv
package cregs_pkg;

    localparam int XLEN    = 32;
    localparam int NUM_REG = 16;
    localparam int IDX_W   = $clog2(NUM_REG);

    localparam int IX_STATUS  = 0;
    localparam int IX_ESTAT   = 1;
    localparam int IX_BSTAT   = 2;
    localparam int IX_IEN     = 3;
    localparam int IX_IPEND   = 4;
    localparam int IX_COREID  = 5;
    localparam int IX_EXC     = 7;
    localparam int IX_PTADDR  = 8;
    localparam int IX_TLBACC  = 9;
    localparam int IX_TLBMISC = 10;
    localparam int IX_FAULT   = 12;

    // status fields
    localparam logic [XLEN-1:0] ST_PIE  = 32'h0000_0001;
    localparam logic [XLEN-1:0] ST_U    = 32'h0000_0002;
    localparam logic [XLEN-1:0] ST_EH   = 32'h0000_0004;
    localparam logic [XLEN-1:0] ST_IH   = 32'h0000_0008;
    localparam logic [XLEN-1:0] ST_IL   = 32'h0000_03F0;
    localparam logic [XLEN-1:0] ST_CRS  = 32'h0000_FC00;
    localparam logic [XLEN-1:0] ST_PRS  = 32'h003F_0000;
    localparam logic [XLEN-1:0] ST_NMI  = 32'h0040_0000;
    localparam logic [XLEN-1:0] ST_RSIE = 32'h0080_0000;

    // page-table address and TLB miscellany fields
    localparam logic [XLEN-1:0] PT_WR   = 32'hFFFF_FFFC;
    localparam logic [XLEN-1:0] TM_WR   = 32'h00FC_3FC0;
    localparam logic [XLEN-1:0] TM_RO   = 32'h0000_003F;
    localparam logic [XLEN-1:0] ALL1    = '1;

    function automatic logic [XLEN-1:0] wr_mask(int idx, bit ext, bit mmu);
        logic [XLEN-1:0] m;
        m = '0;
        unique case (idx)
            IX_STATUS: begin
                m = ST_PIE;
                if (ext) m = m | ST_RSIE | ST_PRS | ST_IL | ST_IH;
                if (mmu) m = m | ST_U | ST_EH;
            end
            IX_ESTAT, IX_BSTAT, IX_FAULT: m = ALL1;
            IX_IEN:     m = ext ? '0 : ALL1;
            IX_PTADDR:  m = mmu ? PT_WR : '0;
            IX_TLBACC:  m = mmu ? ALL1 : '0;
            IX_TLBMISC: m = mmu ? TM_WR : '0;
            default:    m = '0;
        endcase
        return m;
    endfunction

    function automatic logic [XLEN-1:0] ro_mask(int idx, bit ext, bit mmu);
        logic [XLEN-1:0] m;
        m = '0;
        unique case (idx)
            IX_STATUS:         m = ext ? (ST_NMI | ST_CRS) : ST_RSIE;
            IX_COREID, IX_EXC: m = ALL1;
            IX_IPEND:          m = ext ? '0 : ALL1;
            IX_TLBMISC:        m = mmu ? TM_RO : '0;
            default:           m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/cregs_slot.sv
module cregs_slot
    import cregs_pkg::*;
#(
    parameter logic [XLEN-1:0] WMASK = '0,
    parameter logic [XLEN-1:0] RMASK = '0,
    parameter logic [XLEN-1:0] RSTV  = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sw_we,
    input  logic [XLEN-1:0] sw_data,
    input  logic            hw_we,
    input  logic [XLEN-1:0] hw_data,
    output logic [XLEN-1:0] q
);

    logic [XLEN-1:0] after_sw;
    logic [XLEN-1:0] nxt;

    always_comb begin
        after_sw = sw_we ? ((sw_data & WMASK) | (q & RMASK)) : q;
        nxt      = hw_we ? ((after_sw & ~RMASK) | (hw_data & RMASK)) : after_sw;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RSTV & (WMASK | RMASK);
        else        q <= nxt;
    end

    p_ro_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && !hw_we) |=> ((q & RMASK) == $past(q & RMASK)));

    p_wr_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |=> ((q & WMASK) == ($past(sw_data) & WMASK)));

    p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((q & ~(WMASK | RMASK)) == '0));

endmodule

// File: rtl/cregs_pc.sv
module cregs_pc
    import cregs_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld,
    input  logic [XLEN-1:0] ld_val,
    output logic [XLEN-1:0] pc
);

    always_ff @(posedge clk) begin
        if (!rst_n)  pc <= RESET_PC;
        else if (ld) pc <= ld_val;
    end

    p_pc_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (pc == $past(ld_val)));

    p_pc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(pc));

endmodule

// File: rtl/cregs_file.sv
module cregs_file
    import cregs_pkg::*;
#(
    parameter bit               EXT_IRQ_CTRL = 1'b0,
    parameter bit               HAS_MMU      = 1'b1,
    parameter logic [XLEN-1:0]  RESET_PC     = 32'h0000_1000,
    parameter logic [XLEN-1:0]  CORE_ID      = 32'h0000_0003
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0]  wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [XLEN-1:0]  rd_data,
    input  logic [XLEN-1:0]  hw_pend,
    input  logic             hw_exc_we,
    input  logic [XLEN-1:0]  hw_exc_cause,
    input  logic             pc_we,
    input  logic [XLEN-1:0]  pc_wdata,
    output logic [XLEN-1:0]  pc_q
);

    logic [XLEN-1:0] slot_q [NUM_REG];

    for (genvar i = 0; i < NUM_REG; i++) begin : g_slot
        localparam logic [XLEN-1:0] RV =
            (i == IX_STATUS) ? ST_RSIE :
            (i == IX_COREID) ? CORE_ID : '0;
        logic            hw_en;
        logic [XLEN-1:0] hw_val;

        if (i == IX_IPEND && !EXT_IRQ_CTRL) begin : g_pend
            assign hw_en  = 1'b1;
            assign hw_val = hw_pend;
        end else if (i == IX_EXC) begin : g_exc
            assign hw_en  = hw_exc_we;
            assign hw_val = hw_exc_cause;
        end else begin : g_none
            assign hw_en  = 1'b0;
            assign hw_val = '0;
        end

        cregs_slot #(
            .WMASK (wr_mask(i, EXT_IRQ_CTRL, HAS_MMU)),
            .RMASK (ro_mask(i, EXT_IRQ_CTRL, HAS_MMU)),
            .RSTV  (RV)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .sw_we   (wr_en && (wr_idx == IDX_W'(i))),
            .sw_data (wr_data),
            .hw_we   (hw_en),
            .hw_data (hw_val),
            .q       (slot_q[i])
        );
    end

    assign rd_data = slot_q[rd_idx];

    cregs_pc #(.RESET_PC(RESET_PC)) u_pc (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (pc_we),
        .ld_val (pc_wdata),
        .pc     (pc_q)
    );

    p_coreid_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == IDX_W'(IX_COREID)) |-> (rd_data == CORE_ID));

    p_exc_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hw_exc_we |=> (slot_q[IX_EXC] == $past(hw_exc_cause)));

    if (!EXT_IRQ_CTRL) begin : g_chk_pend
        p_pend_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (slot_q[IX_IPEND] == $past(hw_pend)));
    end

endmodule

// File: tb/cregs_file_bench.sv
module cregs_file_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] RPC = 32'h0000_1000;
    localparam logic [31:0] CID = 32'h0000_0003;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_idx = '0;
    logic [31:0] hw_pend = '0;
    logic        hw_exc_we = 1'b0;
    logic [31:0] hw_exc_cause = '0;
    logic        pc_we = 1'b0;
    logic [31:0] pc_wdata = '0;
    logic [31:0] rd_a, rd_b, pc_a, pc_b;

    int n_vec = 0;
    int n_bad = 0;

    logic [31:0] ma [16];
    logic [31:0] mb [16];
    logic [31:0] mpc;

    always #(CLK_PERIOD/2) clk = ~clk;

    cregs_file #(.EXT_IRQ_CTRL(1'b0), .HAS_MMU(1'b1), .RESET_PC(RPC), .CORE_ID(CID)) u_cregs_file (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_a), .hw_pend(hw_pend), .hw_exc_we(hw_exc_we),
        .hw_exc_cause(hw_exc_cause), .pc_we(pc_we), .pc_wdata(pc_wdata), .pc_q(pc_a));

    cregs_file #(.EXT_IRQ_CTRL(1'b1), .HAS_MMU(1'b0), .RESET_PC(RPC), .CORE_ID(CID)) u_cregs_file_alt (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_b), .hw_pend(hw_pend), .hw_exc_we(hw_exc_we),
        .hw_exc_cause(hw_exc_cause), .pc_we(pc_we), .pc_wdata(pc_wdata), .pc_q(pc_b));

    // expected masks, from the requirement text
    function automatic logic [31:0] bw(int i, bit ext, bit mmu);
        case (i)
            0: return 32'h1 | (ext ? 32'h00BF_03F8 : 32'h0) | (mmu ? 32'h6 : 32'h0);
            1, 2, 12: return 32'hFFFF_FFFF;
            3: return ext ? 32'h0 : 32'hFFFF_FFFF;
            8: return mmu ? 32'hFFFF_FFFC : 32'h0;
            9: return mmu ? 32'hFFFF_FFFF : 32'h0;
            10: return mmu ? 32'h00FC_3FC0 : 32'h0;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] br(int i, bit ext, bit mmu);
        case (i)
            0: return ext ? 32'h0040_FC00 : 32'h0080_0000;
            4: return ext ? 32'h0 : 32'hFFFF_FFFF;
            5, 7: return 32'hFFFF_FFFF;
            10: return mmu ? 32'h0000_003F : 32'h0;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(int i, bit ext);
        case (i)
            0: return ext ? "R5" : "R3";
            1, 2, 5, 7, 12: return "R4";
            3, 4: return "R6";
            8, 9, 10: return "R7";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) begin
            ma[i] = '0;
            mb[i] = '0;
        end
        ma[0] = 32'h0080_0000; mb[0] = 32'h0080_0000;
        ma[5] = CID;           mb[5] = CID;
        mpc = RPC;
    endtask

    // called at a negedge: drive, take one edge, check at the next negedge
    task automatic step(bit we, int wi, logic [31:0] wd, int ri, logic [31:0] pend,
                        bit ewe, logic [31:0] ec, bit pwe, logic [31:0] pd,
                        string tag);
        wr_en = we; wr_idx = 4'(wi); wr_data = wd; rd_idx = 4'(ri);
        hw_pend = pend; hw_exc_we = ewe; hw_exc_cause = ec; pc_we = pwe; pc_wdata = pd;
        @(posedge clk);
        if (we) begin
            ma[wi] = (wd & bw(wi, 0, 1)) | (ma[wi] & br(wi, 0, 1));
            mb[wi] = (wd & bw(wi, 1, 0)) | (mb[wi] & br(wi, 1, 0));
        end
        ma[4] = pend;
        if (ewe) begin
            ma[7] = ec;
            mb[7] = ec;
        end
        if (pwe) mpc = pd;
        @(negedge clk);
        chk(tag, rd_a, ma[ri]);
        chk(tag, rd_b, mb[ri]);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] pend_r;
        void'($urandom(32'd2718));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state while reset is held
        for (int i = 0; i < 16; i++) begin
            rd_idx = 4'(i);
            #1;
            chk("R8", rd_a, ma[i]);
            chk("R8", rd_b, mb[i]);
        end
        chk("R8", pc_a, RPC);
        chk("R8", pc_b, RPC);
        rst_n = 1'b1;
        // R8: reset state after release
        for (int i = 0; i < 16; i++) step(0, 0, 0, i, 0, 0, 0, 0, 0, "R8");

        // directed: all ones then all zeros to every index
        for (int i = 0; i < 16; i++) begin
            step(1, i, 32'hFFFF_FFFF, i, 0, 0, 0, 0, 0, tag_of(i, 0));
            chk(tag_of(i, 1), rd_b, mb[i]);
        end
        for (int i = 0; i < 16; i++) step(1, i, 32'h0, i, 0, 0, 0, 0, 0, tag_of(i, 0));
        // R5: status RSIE stays set without the external controller, clears with it
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R5");
        chk("R5", rd_a & 32'h0080_0000, 32'h0080_0000);
        chk("R5", rd_b & 32'h0080_0000, 32'h0);
        // R3: PIE toggles in both configurations
        step(1, 0, 32'h1, 0, 0, 0, 0, 0, 0, "R3");
        chk("R3", rd_a & 32'h1, 32'h1);
        chk("R3", rd_b & 32'h1, 32'h1);

        // R9: hardware exception load, then a software write that must not change it
        step(0, 0, 0, 7, 0, 1, 32'h0000_002C, 0, 0, "R9");
        step(1, 7, 32'hFFFF_FFFF, 7, 0, 0, 0, 0, 0, "R4");
        chk("R9", rd_a, 32'h0000_002C);
        // R6: pending follows hw_pend, software write to it ignored
        step(1, 4, 32'h0, 4, 32'hA5A5_0F0F, 0, 0, 0, 0, "R6");
        chk("R6", rd_a, 32'hA5A5_0F0F);
        chk("R6", rd_b, 32'h0);
        // R10: program counter load and hold
        step(0, 0, 0, 0, 0, 0, 0, 1, 32'h0000_4F00, "R10");
        chk("R10", pc_a, 32'h0000_4F00);
        step(0, 0, 0, 0, 0, 0, 0, 0, 32'hDEAD_BEEF, "R10");
        chk("R10", pc_b, 32'h0000_4F00);

        // R1: constrained random traffic
        for (int k = 0; k < 600; k++) begin
            pend_r = $urandom;
            step(($urandom % 4) != 0, int'($urandom % 16), $urandom, int'($urandom % 16),
                 pend_r, ($urandom % 8) == 0, $urandom, ($urandom % 8) == 0, $urandom, "R1");
            chk("R10", pc_a, mpc);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule